// File: doc/BRIEF.md
# Sample-Pair Waveform Memory Writer

This block is the host-side fill path into a single channel's waveform RAM. The host presents 32-bit write strobes. Each strobe carries two 16-bit samples that are adjacent in time. The block stores each pair as one RAM word. The address of that word is not supplied by the host. An internal slot counter provides it and moves forward by one after every pair.

The RAM holds 4096 samples as 2048 pair words. The counter wraps at the top of the RAM, so a host that writes too much overwrites the oldest words. The slot returns to zero only through the generator reset pulse or the block reset. A busy flag marks the single cycle in which a captured pair is committed to the RAM, so the host needs no handshake.

A separate read port serves a playout engine. Each read returns four samples, which are two adjacent pair words, one cycle after the read address is presented.

Top module: `wavemem_writer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy` is 0. The write slot is 0, so the first strobe after reset lands in pair word 0.
- R2: A strobe stores `wr_data[15:0]` as the earlier sample and `wr_data[31:16]` as the later sample of one pair word. When that word is read back, it appears unchanged in the same bit positions within its 32-bit lane of `rd_data`.
- R3: Each strobe writes the pair word at the current slot, and the slot then advances by one. Cycles without a strobe leave the slot unchanged.
- R4: After pair word 2047 the slot wraps to 0. Further strobes overwrite the earliest words.
- R5: A `gen_rst` pulse returns the slot to 0. If `gen_rst` and `wr_strobe` are high in the same cycle, that pair is written to word 0 and the next pair to word 1.
- R6: `busy` is 1 in exactly the cycle after each accepted strobe, which is the cycle in which the RAM commit happens, and 0 otherwise.
- R7: In the cycle after `rd_quad` = k is presented, `rd_data[31:0]` holds pair word 2k and `rd_data[63:32]` holds pair word 2k+1. A word committed in that same cycle is returned with its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| gen_rst | input | 1 | Generator reset pulse; returns the write slot to zero |
| wr_strobe | input | 1 | One-cycle host write strobe |
| wr_data | input | 32 | Sample pair; earlier sample in [15:0], later sample in [31:16] |
| busy | output | 1 | High in the cycle a pair is committed to RAM |
| rd_quad | input | 10 | Read address in units of four samples |
| rd_data | output | 64 | Two pair words: word 2k in [31:0], word 2k+1 in [63:32] |

## Verification
The bench builds the block with its default sizes: 16-bit samples and an 11-bit pair address. With these sizes, a burst of 2051 back-to-back strobes is enough to wrap the slot and overwrite the first three words within a few thousand cycles. Generator resets are issued on their own, at the same time as a strobe, and in the middle of a fill. Reads that land on a word in the very cycle it is committed show the one-cycle commit pipeline against the registered read.

// File: rtl/wavemem_pkg.sv
package wavemem_pkg;
    localparam int SAMPLE_W = 16;
    localparam int PAIR_AW  = 11;
    localparam int PAIR_W   = 2 * SAMPLE_W;
    localparam int QUAD_AW  = PAIR_AW - 1;
    localparam int QUAD_W   = 2 * PAIR_W;
    localparam int N_BANKS  = 2;

    typedef struct packed {
        logic [SAMPLE_W-1:0] later;
        logic [SAMPLE_W-1:0] earlier;
    } pair_t;

    typedef struct packed {
        logic               valid;
        logic [PAIR_AW-1:0] slot;
        pair_t              pair;
    } commit_t;

    function automatic logic [QUAD_AW-1:0] bank_row(input logic [PAIR_AW-1:0] slot);
        return slot[PAIR_AW-1:1];
    endfunction

    function automatic logic bank_of(input logic [PAIR_AW-1:0] slot);
        return slot[0];
    endfunction
endpackage

// File: rtl/wavemem_slot_ctr.sv
module wavemem_slot_ctr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gen_rst,
    input  logic          advance,
    output logic [AW-1:0] slot
);
    logic [AW-1:0] slot_q;

    always_comb slot = gen_rst ? '0 : slot_q;

    always_ff @(posedge clk) begin
        if (rst)          slot_q <= '0;
        else if (advance) slot_q <= slot + AW'(1);
        else              slot_q <= slot;
    end

    // R5
    slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_rst && !advance) |=> (slot_q == '0));

    // R3
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !gen_rst) |=> (slot_q == $past(slot_q) + AW'(1)));

    // R3
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance && !gen_rst) |=> $stable(slot_q));
endmodule

// File: rtl/wavemem_bank.sv
module wavemem_bank #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/wavemem_writer.sv
module wavemem_writer
    import wavemem_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                gen_rst,
    input  logic                wr_strobe,
    input  logic [PAIR_W-1:0]   wr_data,
    output logic                busy,
    input  logic [QUAD_AW-1:0]  rd_quad,
    output logic [QUAD_W-1:0]   rd_data
);
    logic [PAIR_AW-1:0] slot;
    commit_t            commit_q;

    wavemem_slot_ctr #(.AW(PAIR_AW)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .gen_rst (gen_rst),
        .advance (wr_strobe),
        .slot    (slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_q <= '0;
        end else begin
            commit_q.valid <= wr_strobe;
            if (wr_strobe) begin
                commit_q.slot <= slot;
                commit_q.pair <= pair_t'(wr_data);
            end
        end
    end

    assign busy = commit_q.valid;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = commit_q.valid && (bank_of(commit_q.slot) == 1'(b));
        wavemem_bank #(.AW(QUAD_AW), .DW(PAIR_W)) u_bank (
            .clk   (clk),
            .we    (bank_we),
            .waddr (bank_row(commit_q.slot)),
            .wdata (commit_q.pair),
            .raddr (rd_quad),
            .rdata (rd_data[b*PAIR_W +: PAIR_W])
        );
    end

    // R6
    busy_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> busy);

    // R6
    busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |=> !busy);

    // R3
    commit_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && !gen_rst) |=> (commit_q.slot == $past(u_slot.slot_q)));

    // R5
    commit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe && gen_rst) |=> (commit_q.slot == '0));
endmodule

// File: tb/test_wavemem_writer.sv
module test_wavemem_writer;
    import wavemem_pkg::*;

    logic clk = 0;
    logic rst = 1;
    logic gen_rst = 0;
    logic wr_strobe = 0;
    logic [31:0] wr_data = '0;
    logic busy;
    logic [9:0] rd_quad = '0;
    logic [63:0] rd_data;

    always #2 clk = ~clk;

    wavemem_writer i_wavemem_writer (
        .clk(clk), .rst(rst), .gen_rst(gen_rst), .wr_strobe(wr_strobe),
        .wr_data(wr_data), .busy(busy), .rd_quad(rd_quad), .rd_data(rd_data)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference
    logic [31:0] ref_mem [2048];
    bit          ref_known [2048];
    int          ref_ptr = 0;
    bit          pend_v = 0;
    int          pend_slot = 0;
    logic [31:0] pend_data;
    bit          exp_busy = 0;
    logic [63:0] exp_rd;
    bit          exp_rd_known = 0;
    bit          live = 0;

    initial for (int i = 0; i < 2048; i++) ref_known[i] = 0;

    always @(posedge clk) begin
        int s;
        exp_rd = {ref_mem[2*rd_quad+1], ref_mem[2*rd_quad]};
        exp_rd_known = ref_known[2*rd_quad+1] && ref_known[2*rd_quad];
        if (rst) begin
            ref_ptr = 0; pend_v = 0; exp_busy = 0;
        end else begin
            if (pend_v) begin
                ref_mem[pend_slot] = pend_data;
                ref_known[pend_slot] = 1;
            end
            s = gen_rst ? 0 : ref_ptr;
            pend_v = wr_strobe;
            if (wr_strobe) begin
                pend_slot = s; pend_data = wr_data;
                ref_ptr = (s + 1) % 2048;
            end else begin
                ref_ptr = s;
            end
            exp_busy = wr_strobe;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (live) begin
        chk("R6 busy", {63'd0, busy}, {63'd0, exp_busy});
        if (exp_rd_known) chk("R7 rd_data", rd_data, exp_rd);
    end

    task automatic wr(input logic [31:0] d, input bit g);
        wr_strobe = 1; wr_data = d; gen_rst = g;
        @(negedge clk);
        wr_strobe = 0; gen_rst = 0;
    endtask

    task automatic rd(input int q, output logic [63:0] v);
        rd_quad = 10'(q);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {63'd0, busy}, 64'd0);
        rst = 0;
        @(negedge clk);
        live = 1;
        chk("R1 busy after reset", {63'd0, busy}, 64'd0);

        // R2/R3: first pairs from slot 0, halves in order
        wr(32'h2222_1111, 0);
        wr(32'h4444_3333, 0);
        idle(2);
        wr(32'h6666_5555, 0);
        wr(32'h8888_7777, 0);
        idle(2);
        rd(0, v);
        chk("R1 first write at word 0", v[31:0], 64'h2222_1111);
        chk("R2 earlier sample low", v[15:0], 64'h1111);
        chk("R2 later sample high", v[31:16], 64'h2222);
        chk("R3 second word", v[63:32], 64'h4444_3333);
        rd(1, v);
        chk("R3 gap holds slot", v, 64'h8888_7777_6666_5555);

        // R7 read-before-write on a word being committed
        rd_quad = 10'd2;
        wr(32'hAAAA_0001, 0);
        rd(2, v);
        chk("R7 old data during commit", {63'd0, v[31:0] === 32'hAAAA_0001}, 64'd0);
        rd(2, v);
        chk("R7 new data after commit", v[31:0], 64'hAAAA_0001);

        // R5: generator reset alone, then with strobe
        gen_rst = 1; @(negedge clk); gen_rst = 0;
        wr(32'hBEEF_0000, 0);
        idle(2);
        rd(0, v);
        chk("R5 gen_rst alone", v[31:0], 64'hBEEF_0000);
        chk("R5 word1 untouched", v[63:32], 64'h4444_3333);
        wr(32'h0000_0A0A, 0);
        wr(32'h0000_0B0B, 0);
        wr(32'hC0C0_C0C0, 1);
        wr(32'hD1D1_D1D1, 0);
        idle(2);
        rd(0, v);
        chk("R5 coincident pair to word 0", v[31:0], 64'hC0C0_C0C0);
        chk("R5 next pair to word 1", v[63:32], 64'hD1D1_D1D1);
        rd(1, v);
        chk("R5 pre-reset word 2", v[31:0], 64'h0000_0B0B);

        // R4: fill from 0 and wrap by three
        gen_rst = 1; @(negedge clk); gen_rst = 0;
        for (int i = 0; i < 2051; i++) wr(32'h5A00_0000 + 32'(i), 0);
        idle(2);
        rd(0, v);
        chk("R4 wrapped word 0", v[31:0], 64'h5A00_0800);
        chk("R4 wrapped word 1", v[63:32], 64'h5A00_0801);
        rd(1, v);
        chk("R4 wrapped word 2", v[31:0], 64'h5A00_0802);
        chk("R4 untouched word 3", v[63:32], 64'h5A00_0003);
        rd(1023, v);
        chk("R7 top quad", v, 64'h5A00_07FF_5A00_07FE);
        for (int q = 0; q < 1024; q += 37) rd(q, v);

        // R1: block reset returns slot to zero
        rst = 1; @(negedge clk); rst = 0;
        chk("R1 busy after second reset", {63'd0, busy}, 64'd0);
        wr(32'h1234_5678, 0);
        idle(2);
        rd(0, v);
        chk("R1 slot zero after rst", v[31:0], 64'h1234_5678);

        idle(2);
        summary();
    end
endmodule